// File: doc/BRIEF.md
# I2C Memory-Slave Read Engine

This block is an I2C target that answers read requests against an 8192-by-8 byte array. A single internal address pointer is shared by every transaction and is kept from one transaction to the next. The block oversamples SCL and SDA in the system clock domain and finds Start, repeated Start and Stop conditions. It pulls SDA low through an open-drain enable output. The array is outside the block. The engine puts the pointer on an address port and takes the byte back combinationally on a data port.

A write phase is a select byte with RW=0 followed by two address bytes, and it loads the pointer. If a repeated Start and a read select follow the write phase with no Stop between them, the transfer is a random read. A select with RW=1 straight after a Start reads from wherever the pointer stands, and that is a current-address read. If the master acknowledges each byte, the engine keeps streaming consecutive bytes and the pointer wraps from the top of the array to zero. A missing acknowledge after a byte makes the engine release the line and wait in standby for the next Start. Data bytes that follow the address in a write phase are acknowledged and then dropped. A write-lock input exists, but it has no effect on any read.

Top module: `i2c_mem_reader`

## Requirements
- R1: After reset, `sda_oe_o` is 0 and `mem_addr_o` is 0.
- R2: The select byte is taken MSB first. Bits 7:4 must equal 1010, bits 3:1 must equal `strap_i`, and bit 0 is RW (1 = read). On a match the engine drives SDA low for the ninth clock. On a mismatch it leaves SDA released and ignores the bus until the next Start.
- R3: In a write phase the engine acknowledges both address bytes, high byte first, and each byte arrives MSB first. The pointer is loaded with the low 13 bits of that 16-bit value, so bits 15:13 are ignored.
- R4: A current-address read returns the byte at the pointer, MSB first on SDA. The pointer advances by one for every byte that is output.
- R5: A write phase, then a repeated Start, then a read select returns the byte at the address just loaded.
- R6: When the master acknowledges a data byte, the engine outputs the byte at the next consecutive address.
- R7: The pointer wraps from 1FFFh to 0000h, and output carries on from there.
- R8: When SDA is high at the ninth clock after a read byte, the engine stops driving and stays released through any further SCL pulses until the next Start.
- R9: A Stop at any point leaves SDA released, returns the engine to idle and keeps the pointer value.
- R10: The value of `lock_i` has no effect on any read result.
- R11: Data bytes that follow the two address bytes are acknowledged and discarded, and they leave the pointer unchanged.
- R12: `sda_oe_o` changes only while SCL is low. Start and Stop are recognised only while SCL is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen at the pin |
| sda_i | input | 1 | Serial data line as seen at the pin (wired-AND level) |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| strap_i | input | 3 | Low select-code bits set by board straps |
| lock_i | input | 1 | Write-lock flag; has no effect on reads |
| mem_addr_o | output | 13 | Array address, equal to the internal pointer |
| mem_data_i | input | 8 | Array byte at `mem_addr_o`, combinational |

## Verification
The assertions take for granted that the master changes SDA only while SCL is low, apart from deliberate Start and Stop conditions. They also take for granted that every SCL level lasts much longer than the two-stage synchroniser delay. Under those conditions the engine's own SDA changes, which follow a detected SCL fall, land while the raw SCL pin is still low. The stimulus holds every quarter of an SCL period for ten system clocks. It moves SDA only at the quarter point after a falling SCL edge, except in Start and Stop sequences.

// File: rtl/i2c_rd_pkg.sv
package i2c_rd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEV,
        ST_AHI,
        ST_ALO,
        ST_WDAT,
        ST_ACK,
        ST_RD,
        ST_RACK
    } rd_state_e;

    localparam logic [3:0] FAMILY_CODE = 4'b1010;

    function automatic logic sel_match(input logic [7:0] sel, input logic [2:0] strap);
        return (sel[7:4] == FAMILY_CODE) && (sel[3:1] == strap);
    endfunction

    function automatic logic is_rx_state(input rd_state_e st);
        return (st == ST_DEV) || (st == ST_AHI) || (st == ST_ALO) || (st == ST_WDAT);
    endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o,
    output logic prev_o,
    output logic rise_o,
    output logic fall_o
);
    localparam int DEPTH = STAGES + 1;

    logic [DEPTH-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[DEPTH-2:0], line_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= sh_d;
    end

    assign line_o = sh_q[STAGES-1];
    assign prev_o = sh_q[STAGES];
    assign rise_o = line_o & ~prev_o;
    assign fall_o = ~line_o & prev_o;
endmodule

// File: rtl/i2c_bus_cond.sv
module i2c_bus_cond (
    input  logic scl,
    input  logic scl_prev,
    input  logic sda,
    input  logic sda_prev,
    output logic start_o,
    output logic stop_o
);
    logic scl_held_high;

    always_comb begin
        scl_held_high = scl & scl_prev;
        start_o = scl_held_high & sda_prev & ~sda;
        stop_o  = scl_held_high & ~sda_prev & sda;
    end
endmodule

// File: rtl/i2c_rd_ctrl.sv
module i2c_rd_ctrl
    import i2c_rd_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              sda,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [2:0]        strap,
    input  logic [7:0]        mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              sda_oe,
    output logic              byte_load
);
    localparam int HI_W = ADDR_W - 8;
    localparam logic [3:0] BITS_PER_BYTE = 4'd8;

    typedef struct packed {
        rd_state_e         st;
        rd_state_e         ack_nxt;
        logic [3:0]        bitcnt;
        logic [7:0]        sh;
        logic              oe;
        logic [HI_W-1:0]   hi;
        logic [ADDR_W-1:0] ptr;
    } regs_t;

    localparam regs_t REGS_RST = '{
        st:      ST_IDLE,
        ack_nxt: ST_IDLE,
        bitcnt:  4'd0,
        sh:      8'd0,
        oe:      1'b0,
        hi:      '0,
        ptr:     '0
    };

    regs_t q, d;
    logic  load_d;

    always_comb begin
        d      = q;
        load_d = 1'b0;
        if (stop_det) begin
            d.st     = ST_IDLE;
            d.oe     = 1'b0;
            d.bitcnt = 4'd0;
        end else if (start_det) begin
            d.st     = ST_DEV;
            d.oe     = 1'b0;
            d.bitcnt = 4'd0;
        end else begin
            case (q.st)
                ST_IDLE: begin
                    d.oe = 1'b0;
                end
                ST_DEV, ST_AHI, ST_ALO, ST_WDAT: begin
                    if (scl_rise && q.bitcnt != BITS_PER_BYTE) begin
                        d.sh     = {q.sh[6:0], sda};
                        d.bitcnt = q.bitcnt + 4'd1;
                    end else if (scl_fall && q.bitcnt == BITS_PER_BYTE) begin
                        d.bitcnt = 4'd0;
                        d.oe     = 1'b1;
                        d.st     = ST_ACK;
                        case (q.st)
                            ST_DEV: begin
                                if (sel_match(q.sh, strap)) begin
                                    d.ack_nxt = q.sh[0] ? ST_RD : ST_AHI;
                                end else begin
                                    d.oe = 1'b0;
                                    d.st = ST_IDLE;
                                end
                            end
                            ST_AHI: begin
                                d.hi      = q.sh[HI_W-1:0];
                                d.ack_nxt = ST_ALO;
                            end
                            ST_ALO: begin
                                d.ptr     = {q.hi, q.sh};
                                d.ack_nxt = ST_WDAT;
                            end
                            default: begin
                                d.ack_nxt = ST_WDAT;
                            end
                        endcase
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        d.oe     = 1'b0;
                        d.bitcnt = 4'd0;
                        if (q.ack_nxt == ST_RD) begin
                            d.sh   = mem_rdata;
                            d.oe   = ~mem_rdata[7];
                            d.ptr  = q.ptr + ADDR_W'(1);
                            d.st   = ST_RD;
                            load_d = 1'b1;
                        end else begin
                            d.st = q.ack_nxt;
                        end
                    end
                end
                ST_RD: begin
                    if (scl_rise) begin
                        d.bitcnt = q.bitcnt + 4'd1;
                    end else if (scl_fall) begin
                        if (q.bitcnt == BITS_PER_BYTE) begin
                            d.oe     = 1'b0;
                            d.bitcnt = 4'd0;
                            d.st     = ST_RACK;
                        end else begin
                            d.sh = {q.sh[6:0], 1'b0};
                            d.oe = ~q.sh[6];
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise && sda) begin
                        d.oe = 1'b0;
                        d.st = ST_IDLE;
                    end else if (scl_fall) begin
                        d.sh     = mem_rdata;
                        d.oe     = ~mem_rdata[7];
                        d.ptr    = q.ptr + ADDR_W'(1);
                        d.bitcnt = 4'd0;
                        d.st     = ST_RD;
                        load_d   = 1'b1;
                    end
                end
                default: begin
                    d = REGS_RST;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= REGS_RST;
        else        q <= d;
    end

    assign mem_addr  = q.ptr;
    assign sda_oe    = q.oe;
    assign byte_load = load_d;
endmodule

// File: rtl/i2c_mem_reader.sv
module i2c_mem_reader #(
    parameter int ADDR_W      = 13,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe_o,
    input  logic [2:0]        strap_i,
    input  logic              lock_i,
    output logic [ADDR_W-1:0] mem_addr_o,
    input  logic [7:0]        mem_data_i
);
    logic scl_s, scl_p, scl_rise, scl_fall;
    logic sda_s, sda_p, sda_rise_unused, sda_fall_unused;
    logic start_det, stop_det, byte_load;
    logic unused_lock;

    assign unused_lock = lock_i;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
        .clk(clk), .rst_n(rst_n), .line_i(scl_i),
        .line_o(scl_s), .prev_o(scl_p), .rise_o(scl_rise), .fall_o(scl_fall)
    );

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
        .clk(clk), .rst_n(rst_n), .line_i(sda_i),
        .line_o(sda_s), .prev_o(sda_p), .rise_o(sda_rise_unused), .fall_o(sda_fall_unused)
    );

    i2c_bus_cond u_cond (
        .scl(scl_s), .scl_prev(scl_p), .sda(sda_s), .sda_prev(sda_p),
        .start_o(start_det), .stop_o(stop_det)
    );

    i2c_rd_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .sda(sda_s),
        .start_det(start_det), .stop_det(stop_det),
        .strap(strap_i), .mem_rdata(mem_data_i),
        .mem_addr(mem_addr_o), .sda_oe(sda_oe_o), .byte_load(byte_load)
    );
endmodule

// File: rtl/i2c_rd_checker.sv
module i2c_rd_checker #(
    parameter int ADDR_W = 13
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_i,
    input logic              sda_oe_o,
    input logic [ADDR_W-1:0] mem_addr_o,
    input logic              start_det,
    input logic              stop_det,
    input logic              byte_load
);
    // R12: the open-drain enable moves only while the raw clock line is low
    a_r12_oe_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe_o != $past(sda_oe_o)) |-> !scl_i);

    // R9: a Stop releases the line
    a_r9_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe_o);

    // R9: a Stop keeps the pointer
    a_r9_stop_keeps_ptr: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (mem_addr_o == $past(mem_addr_o)));

    // R2: a Start (or repeated Start) never leaves the line pulled low
    a_r2_start_releases: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> !sda_oe_o);

    // R4 / R7: each byte taken for output advances the pointer by one, wrapping
    a_r4_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
        byte_load |=> (mem_addr_o == $past(mem_addr_o) + ADDR_W'(1)));
endmodule

bind i2c_mem_reader i2c_rd_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe_o(sda_oe_o),
    .mem_addr_o(mem_addr_o), .start_det(start_det), .stop_det(stop_det),
    .byte_load(byte_load)
);

// File: tb/i2c_mem_reader_tb.sv
module i2c_mem_reader_tb;
    localparam int Q = 10;
    localparam logic [2:0] STRAP = 3'b101;
    localparam logic [7:0] SEL_W = {4'b1010, STRAP, 1'b0};
    localparam logic [7:0] SEL_R = {4'b1010, STRAP, 1'b1};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic lock = 1'b0;
    logic sda_oe;
    logic sda_bus;
    logic [12:0] mem_addr;
    logic [7:0] mem_data;
    int n_chk = 0;
    int n_fail = 0;
    int r12_viol = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    function automatic logic [7:0] mem_f(input logic [12:0] a);
        return a[7:0] ^ {a[12:8], 3'b011} ^ 8'h5A;
    endfunction

    assign sda_bus  = sda_m & ~sda_oe;
    assign mem_data = mem_f(mem_addr);

    i2c_mem_reader u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
        .sda_oe_o(sda_oe), .strap_i(STRAP), .lock_i(lock),
        .mem_addr_o(mem_addr), .mem_data_i(mem_data)
    );

    // R12 monitor: enable must not move across a negedge pair with clock line high
    logic prev_oe = 1'b0, prev_scl = 1'b1;
    always @(negedge clk) begin
        if (rst_n && scl_m && prev_scl && (sda_oe != prev_oe)) r12_viol++;
        prev_oe  <= sda_oe;
        prev_scl <= scl_m;
    end

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic qw;
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start;
        sda_m = 1'b1; qw; scl_m = 1'b1; qw; sda_m = 1'b0; qw; scl_m = 1'b0; qw;
    endtask

    task automatic bus_stop;
        sda_m = 1'b0; qw; scl_m = 1'b1; qw; sda_m = 1'b1; qw;
    endtask

    task automatic wr_byte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; qw; scl_m = 1'b1; qw; qw; scl_m = 1'b0; qw;
        end
        sda_m = 1'b1; qw; scl_m = 1'b1; qw;
        acked = !sda_bus;
        qw; scl_m = 1'b0; qw;
    endtask

    task automatic rd_byte(input bit ack, output logic [7:0] d);
        for (int i = 7; i >= 0; i--) begin
            sda_m = 1'b1; qw; scl_m = 1'b1; qw;
            d[i] = sda_bus;
            qw; scl_m = 1'b0; qw;
        end
        sda_m = !ack; qw; scl_m = 1'b1; qw; qw; scl_m = 1'b0; qw;
        sda_m = 1'b1;
    endtask

    task automatic write_phase(input logic [15:0] a);
        bit ak;
        bus_start;
        wr_byte(SEL_W, ak);  chk("R2 select write ack", 16'(ak), 16'd1);
        wr_byte(a[15:8], ak); chk("R3 address high ack", 16'(ak), 16'd1);
        wr_byte(a[7:0], ak);  chk("R3 address low ack", 16'(ak), 16'd1);
    endtask

    task automatic t_reset;
        chk("R1 reset oe", 16'(sda_oe), 16'd0);
        chk("R1 reset pointer", 16'(mem_addr), 16'd0);
    endtask

    task automatic t_current_read_first;
        bit ak; logic [7:0] d;
        bus_start;
        wr_byte(SEL_R, ak); chk("R4 read select ack", 16'(ak), 16'd1);
        rd_byte(1'b0, d);   chk("R4 current read at zero", 16'(d), 16'(mem_f(13'h0)));
        bus_stop;
        chk("R4 pointer advanced", 16'(mem_addr), 16'h0001);
    endtask

    task automatic t_bad_select;
        bit ak;
        bus_start;
        wr_byte({4'b1010, 3'b010, 1'b0}, ak); chk("R2 strap mismatch nack", 16'(ak), 16'd0);
        wr_byte(8'h00, ak); chk("R2 ignored after mismatch", 16'(ak), 16'd0);
        bus_stop;
        bus_start;
        wr_byte({4'b1011, STRAP, 1'b1}, ak); chk("R2 family mismatch nack", 16'(ak), 16'd0);
        bus_stop;
        chk("R2 pointer untouched", 16'(mem_addr), 16'h0001);
    endtask

    task automatic t_random_read;
        bit ak; logic [7:0] d;
        lock = 1'b1;
        write_phase(16'hE123);
        bus_start;
        wr_byte(SEL_R, ak); chk("R5 read select ack", 16'(ak), 16'd1);
        rd_byte(1'b0, d);   chk("R5 R3 R10 random read top bits ignored", 16'(d), 16'(mem_f(13'h0123)));
        bus_stop;
        chk("R4 pointer after random read", 16'(mem_addr), 16'h0124);
    endtask

    task automatic t_current_locked;
        bit ak; logic [7:0] d;
        lock = 1'b1;
        bus_start;
        wr_byte(SEL_R, ak);
        rd_byte(1'b0, d); chk("R10 current read with lock set", 16'(d), 16'(mem_f(13'h0124)));
        bus_stop;
        lock = 1'b0;
    endtask

    task automatic t_sequential_wrap;
        bit ak; logic [7:0] d; bit saw_drive;
        write_phase(16'h1FFE);
        bus_start;
        wr_byte(SEL_R, ak);
        rd_byte(1'b1, d); chk("R6 first sequential byte", 16'(d), 16'(mem_f(13'h1FFE)));
        rd_byte(1'b1, d); chk("R6 top of array", 16'(d), 16'(mem_f(13'h1FFF)));
        rd_byte(1'b1, d); chk("R7 wrapped to zero", 16'(d), 16'(mem_f(13'h0000)));
        rd_byte(1'b0, d); chk("R7 continues after wrap", 16'(d), 16'(mem_f(13'h0001)));
        // R8: further clocks after the missing acknowledge see a released line
        saw_drive = 1'b0;
        for (int i = 0; i < 9; i++) begin
            qw; scl_m = 1'b1; qw;
            if (!sda_bus) saw_drive = 1'b1;
            qw; scl_m = 1'b0; qw;
        end
        chk("R8 standby after nack", 16'(saw_drive), 16'd0);
        bus_stop;
        chk("R8 pointer after standby", 16'(mem_addr), 16'h0002);
    endtask

    task automatic t_data_discard;
        bit ak; logic [7:0] d;
        write_phase(16'h0040);
        wr_byte(8'h55, ak); chk("R11 data byte ack", 16'(ak), 16'd1);
        wr_byte(8'hAA, ak); chk("R11 second data byte ack", 16'(ak), 16'd1);
        bus_stop;
        chk("R11 pointer unchanged by data", 16'(mem_addr), 16'h0040);
        bus_start;
        wr_byte(SEL_R, ak);
        rd_byte(1'b0, d); chk("R11 read after discarded data", 16'(d), 16'(mem_f(13'h0040)));
        bus_stop;
    endtask

    task automatic t_stop_keeps;
        bit ak; logic [7:0] d;
        write_phase(16'h0300);
        bus_stop;
        chk("R9 pointer kept across stop", 16'(mem_addr), 16'h0300);
        bus_start;
        wr_byte(SEL_W, ak);
        wr_byte(8'h07, ak);
        bus_stop;
        chk("R9 stop mid address oe", 16'(sda_oe), 16'd0);
        chk("R9 stop mid address keeps pointer", 16'(mem_addr), 16'h0300);
        bus_start;
        wr_byte(SEL_R, ak);
        rd_byte(1'b0, d); chk("R9 read after stop", 16'(d), 16'(mem_f(13'h0300)));
        bus_stop;
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_reset;
        t_current_read_first;
        t_bad_select;
        t_random_read;
        t_current_locked;
        t_sequential_wrap;
        t_data_discard;
        t_stop_keeps;
        chk("R12 oe stable while clock high", 16'(r12_viol), 16'd0);
        finish_run;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            finish_run;
        end
    end
endmodule